// File: doc/BRIEF.md
# Daisy-chainable SPI slave with frame-length check

This block is the serial front end of a small register-based peripheral. A host selects it with an active-low chip select, clocks bits in on the falling edge of the serial clock and reads bits out, which change on the rising edge. Data moves most significant bit first through an 8-bit shift register, so in frames longer than eight bits the slave passes the earlier bits through to its data-out pin. This lets several slaves share one select line in a daisy chain.

All pins are sampled by a faster system clock through two-flop synchronizers, and edges are detected in that clock domain. A frame counts only if the number of serial clock falls is a nonzero multiple of eight. A frame of any other length, including zero, raises an error flag and the command is discarded. At the start of the next access the flag is ORed with the data-in level onto data-out, so a fault anywhere in the chain reaches the host on its first bit. A valid frame's last byte is decoded into a read-select or a write to one of eight 3-bit registers.

Top module: `spi_chain_slave`

## Requirements
- R1: Within three clk_i cycles of a change on cs_ni, sdo_oe_o equals the inverse of cs_ni. sdo_o is 0 whenever sdo_oe_o is 0.
- R2: Toggling sck_i and sdi_i while cs_ni is high changes no register, selected address or error flag.
- R3: From the chip-select fall until the first serial-clock rise, sdo_o equals the error flag ORed with the current sdi_i level.
- R4: Each access starts by loading the response byte {2'b00, selected address[2:0], contents of that register[2:0]}. It is shifted out MSB first, and each bit appears on sdo_o after a serial-clock rise.
- R5: In frames longer than eight bits, the bit presented after rise k+8 is the data-in bit sampled at fall k (daisy-chain pass-through).
- R6: A valid frame whose last byte has bits [7:6]=01 writes bits [2:0] into the register addressed by bits [5:3], at chip-select rise.
- R7: A valid frame whose last byte has bits [7:6]=00 selects the address in bits [5:3] for the response of the following accesses.
- R8: An access with zero serial-clock falls, or a count that is not a multiple of eight, sets the error flag and its command has no effect.
- R9: In a valid frame longer than eight bits, only the last eight bits received are decoded.
- R10: The error flag clears at the end of a valid access that began with the flag set. If that access is invalid, the flag stays set.
- R11: Opcodes 10 and 11 in a valid frame change neither registers, selected address nor error flag.
- R12: After reset all registers and the selected address are 0, the error flag is clear and sdo_oe_o is 0.
- R13: A final serial-clock fall seen in the same clk_i cycle as the chip-select rise is counted and shifted before the frame is judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Data-out drive enable (low means high impedance) |

## Verification
After synchronization, the last serial-clock fall of a frame and the chip-select rise that ends it can land in the same system-clock cycle. In that case the shift, the bit count and the frame verdict must all be made together. The bench provokes this by releasing chip select on the same edge that lowers the serial clock for the final bit of a write. It then judges the result at the ports: the next access must begin with no error reported on data-out and must read back the value just written. A second pairing is also checked: the error flag is reported at the start of an access, and that same access's verdict either clears it or keeps it.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int OP_W     = 2;
  localparam int ADDR_W   = 3;
  localparam int VAL_W    = 3;
  localparam int FRAME_W  = OP_W + ADDR_W + VAL_W;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int CNT_W    = $clog2(FRAME_W);

  typedef enum logic [OP_W-1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RSV_A = 2'b10,
    OP_RSV_B = 2'b11
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [VAL_W-1:0]  val;
  } frame_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign lvl_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_chain_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_lvl_i,
  input  logic               sck_lvl_i,
  input  logic               sdi_lvl_i,
  input  logic [FRAME_W-1:0] resp_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  output logic               frame_end_o,
  output logic               frame_ok_o,
  output logic               err_o,
  output frame_t             frame_o
);
  logic               cs_d_q, sck_d_q;
  logic               in_access, cs_fall, cs_rise, sck_rise, sck_fall;
  logic [FRAME_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               any_q, any_d;
  logic               hold_q, sdo_q, err_q, seen_q;

  assign in_access = ~cs_d_q;
  assign cs_fall   = cs_d_q & ~cs_lvl_i;
  assign cs_rise   = ~cs_d_q & cs_lvl_i;
  assign sck_rise  = in_access & sck_lvl_i & ~sck_d_q;
  assign sck_fall  = in_access & ~sck_lvl_i & sck_d_q;

  // next-state includes a fall that coincides with the select release
  always_comb begin
    shift_d = sck_fall ? {shift_q[FRAME_W-2:0], sdi_lvl_i} : shift_q;
    cnt_d   = cnt_q + CNT_W'(sck_fall);
    any_d   = any_q | sck_fall;
  end

  assign frame_ok_o  = cs_rise & any_d & (cnt_d == '0);
  assign frame_end_o = cs_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d_q  <= 1'b1;
      sck_d_q <= 1'b0;
    end else begin
      cs_d_q  <= cs_lvl_i;
      sck_d_q <= sck_lvl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
      any_q   <= 1'b0;
      hold_q  <= 1'b1;
      sdo_q   <= 1'b0;
      err_q   <= 1'b0;
      seen_q  <= 1'b0;
    end else if (cs_fall) begin
      shift_q <= resp_i;
      cnt_q   <= '0;
      any_q   <= 1'b0;
      hold_q  <= 1'b1;
      seen_q  <= err_q;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      any_q   <= any_d;
      if (sck_rise) begin
        hold_q <= 1'b0;
        sdo_q  <= shift_q[FRAME_W-1];
      end
      if (cs_rise) begin
        hold_q <= 1'b1;
        if (!frame_ok_o)  err_q <= 1'b1;
        else if (seen_q)  err_q <= 1'b0;
      end
    end
  end

  assign sdo_oe_o = ~cs_lvl_i;
  assign sdo_o    = sdo_oe_o & (hold_q ? (err_q | sdi_lvl_i) : sdo_q);
  assign err_o    = err_q;
  assign frame_o  = frame_t'(shift_d);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_chain_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  frame_t             frame_i,
  output logic [FRAME_W-1:0] resp_o,
  output logic               wr_en_o
);
  logic [NUM_REGS-1:0][VAL_W-1:0] vals;
  logic [ADDR_W-1:0]              rd_addr_q;
  logic                           rd_sel;

  assign wr_en_o = commit_i && (frame_i.op == OP_WRITE);
  assign rd_sel  = commit_i && (frame_i.op == OP_READ);

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [VAL_W-1:0] val_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                      val_q <= '0;
        else if (wr_en_o && (frame_i.addr == ADDR_W'(g))) val_q <= frame_i.val;
      end
      assign vals[g] = val_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rd_addr_q <= '0;
    else if (rd_sel) rd_addr_q <= frame_i.addr;
  end

  assign resp_o = {{OP_W{1'b0}}, rd_addr_q, vals[rd_addr_q]};
endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_chain_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic               cs_lvl_w, sck_lvl_w, sdi_lvl_w;
  logic               frame_end_w, frame_ok_w, err_w, wr_en_w;
  logic [FRAME_W-1:0] resp_w;
  frame_t             frame_w;

  spi_pin_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i ({cs_ni, sck_i, sdi_i}),
    .lvl_o ({cs_lvl_w, sck_lvl_w, sdi_lvl_w})
  );

  spi_frame_ctrl u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_lvl_i   (cs_lvl_w),
    .sck_lvl_i  (sck_lvl_w),
    .sdi_lvl_i  (sdi_lvl_w),
    .resp_i     (resp_w),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .frame_end_o(frame_end_w),
    .frame_ok_o (frame_ok_w),
    .err_o      (err_w),
    .frame_o    (frame_w)
  );

  spi_reg_bank u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(frame_ok_w),
    .frame_i (frame_w),
    .resp_o  (resp_w),
    .wr_en_o (wr_en_w)
  );
endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic cs_lvl,
  input logic sdi_lvl,
  input logic frame_end,
  input logic frame_ok,
  input logic err,
  input logic wr_en
);
  a_r1_hiz_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni && $past(cs_ni) && $past(cs_ni, 2) |-> !sdo_oe_o);

  a_r1_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);

  a_r3_first_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_lvl) |-> sdo_o == (err | sdi_lvl));

  a_r8_err_on_bad_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end && !frame_ok |=> err);

  a_r6_write_needs_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> frame_ok);

  a_r10_err_moves_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(err));
endmodule

bind spi_chain_slave spi_chain_slave_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .sdo_o    (sdo_o),
  .sdo_oe_o (sdo_oe_o),
  .cs_lvl   (cs_lvl_w),
  .sdi_lvl  (sdi_lvl_w),
  .frame_end(frame_end_w),
  .frame_ok (frame_ok_w),
  .err      (err_w),
  .wr_en    (wr_en_w)
);

// File: tb/sim_spi_chain_slave.sv
module sim_spi_chain_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  spi_chain_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  // behavioural reference: pin history, bit queues, integer registers
  bit h_cs[4], h_sck[4], h_sdi[4];
  bit outq[$];
  int nfall, m_regs[8], m_rd;
  bit m_err, m_seen, m_hold, m_sdo, exp_oe, exp_sdo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin h_cs[i] = 1; h_sck[i] = 0; h_sdi[i] = 0; end
      outq.delete(); nfall = 0; m_rd = 0;
      for (int i = 0; i < 8; i++) m_regs[i] = 0;
      m_err = 0; m_seen = 0; m_hold = 1; m_sdo = 0; exp_oe = 0; exp_sdo = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin h_cs[i] = h_cs[i-1]; h_sck[i] = h_sck[i-1]; h_sdi[i] = h_sdi[i-1]; end
      h_cs[0] = cs_n; h_sck[0] = sck; h_sdi[0] = sdi;
      if (h_cs[3] && !h_cs[2]) begin
        outq.delete();
        outq.push_back(0); outq.push_back(0);
        for (int b = 2; b >= 0; b--) outq.push_back(bit'((m_rd >> b) & 1));
        for (int b = 2; b >= 0; b--) outq.push_back(bit'((m_regs[m_rd] >> b) & 1));
        nfall = 0; m_hold = 1; m_seen = m_err;
      end else begin
        if (!h_cs[3] && h_sck[3] && !h_sck[2]) begin
          void'(outq.pop_front()); outq.push_back(h_sdi[2]); nfall++;
        end
        if (!h_cs[3] && !h_sck[3] && h_sck[2]) begin m_hold = 0; m_sdo = outq[0]; end
        if (!h_cs[3] && h_cs[2]) begin
          if (nfall > 0 && nfall % 8 == 0) begin
            int op, ad, vl;
            op = outq[0] * 2 + outq[1];
            ad = outq[2] * 4 + outq[3] * 2 + outq[4];
            vl = outq[5] * 4 + outq[6] * 2 + outq[7];
            if (op == 1) m_regs[ad] = vl;
            else if (op == 0) m_rd = ad;
            if (m_seen) m_err = 0;
          end else m_err = 1;
          m_hold = 1;
        end
      end
      exp_oe  = !h_cs[1];
      exp_sdo = exp_oe ? (m_hold ? (m_err | h_sdi[1]) : m_sdo) : 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (sdo_oe !== exp_oe) begin
        errors++; $display("FAIL R1 oe act=%b exp=%b t=%0t", sdo_oe, exp_oe, $time);
      end
      checks++;
      if (sdo !== exp_sdo) begin
        errors++; $display("FAIL R4 sdo act=%b exp=%b t=%0t", sdo, exp_sdo, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic spi_xfer(input logic [31:0] tx, input int nbits, input bit coincide,
                          output logic first, output logic [31:0] rx);
    rx = '0;
    @(negedge clk);
    cs_n = 1'b0;
    if (nbits > 0) sdi = tx[nbits-1];
    repeat (5) @(negedge clk);
    first = sdo;
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b1;
      if (i > 0) sdi = tx[nbits-1-i];
      repeat (5) @(negedge clk);
      rx[nbits-1-i] = sdo;
      if (coincide && i == nbits - 1) begin
        sck = 1'b0; cs_n = 1'b1;
      end else begin
        sck = 1'b0;
        repeat (5) @(negedge clk);
      end
    end
    if (!coincide) cs_n = 1'b1;
    repeat (6) @(negedge clk);
    sdi = 1'b0;
  endtask

  initial begin
    logic f;
    logic [31:0] r;
    repeat (3) @(negedge clk);
    chk("R12 oe in reset", {31'd0, sdo_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 oe after reset", {31'd0, sdo_oe}, 32'd0);
    chk("R1 sdo idle", {31'd0, sdo}, 32'd0);

    spi_xfer(32'h5D, 8, 0, f, r);            // write reg3=5
    chk("R12 reset response", r[7:0], 32'h00);
    chk("R3 first bit clean", {31'd0, f}, 32'd0);
    spi_xfer(32'h72, 8, 0, f, r);            // write reg6=2
    spi_xfer(32'h18, 8, 0, f, r);            // select reg3
    spi_xfer(32'h18, 8, 0, f, r);
    chk("R6 R7 readback reg3", r[7:0], 32'h1D);

    spi_xfer(32'hA530, 16, 0, f, r);         // pass-through, decode select reg6
    chk("R4 first byte of 16", r[15:8], 32'h1D);
    chk("R5 daisy pass-through", r[7:0], 32'hA5);
    spi_xfer(32'h18, 8, 0, f, r);
    chk("R9 last byte decoded", r[7:0], 32'h32);

    spi_xfer(32'h59, 7, 0, f, r);            // short frame, write dropped
    spi_xfer(32'h18, 8, 0, f, r);
    chk("R8 flag after short frame", {31'd0, f}, 32'd1);
    chk("R8 write dropped", r[7:0], 32'h1D);
    spi_xfer(32'h18, 8, 0, f, r);
    chk("R10 flag cleared", {31'd0, f}, 32'd0);

    spi_xfer(32'h0, 0, 0, f, r);             // empty access
    spi_xfer(32'h031, 9, 0, f, r);
    chk("R8 flag after empty access", {31'd0, f}, 32'd1);
    spi_xfer(32'h18, 8, 0, f, r);
    chk("R10 flag kept by bad frame", {31'd0, f}, 32'd1);
    spi_xfer(32'h98, 8, 0, f, r);            // reserved opcode 10
    chk("R3 first bit follows sdi", {31'd0, f}, 32'd1);
    spi_xfer(32'hD8, 8, 0, f, r);            // reserved opcode 11

    for (int k = 0; k < 6; k++) begin        // activity with select high
      @(negedge clk); sck = ~sck; sdi = ~sdi;
      repeat (3) @(negedge clk);
    end
    sck = 1'b0; sdi = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 oe stays off", {31'd0, sdo_oe}, 32'd0);
    spi_xfer(32'h18, 8, 0, f, r);
    chk("R2 R11 no error", {31'd0, f}, 32'd0);
    chk("R11 reg3 unchanged", r[7:0], 32'h1D);

    spi_xfer(32'h5F, 8, 1, f, r);            // write reg3=7, final fall with release
    spi_xfer(32'h18, 8, 0, f, r);
    chk("R13 coincident end accepted", {31'd0, f}, 32'd0);
    chk("R13 coincident write", r[7:0], 32'h1F);

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule